// File: doc/BRIEF.md
# Wormhole XY Mesh Router

This block is a five-port switching node for a two-dimensional grid network on a chip. Four ports face the grid neighbours (north, east, south and west) and one faces the locally attached resource. Messages travel as packets cut into flits. The first flit of a packet opens a path through the node, the remaining flits follow that path, and the last flit closes it again. This is wormhole switching, so each input needs only a few flits of storage.

The output for a packet is chosen by dimension-ordered routing. The packet first moves along X until its column matches the destination column, and only then moves along Y. When both coordinates match the node's own position, which is set by parameters, the packet goes to the local port. Every link carries one flit per four-phase request/acknowledge exchange. The sender waits for the acknowledge to return low before it offers the next flit. Each output has its own round-robin arbiter, and that arbiter keeps the output bound to one input from the first flit of a packet to the acknowledge of its last flit.

A grid of these nodes is built by joining each output's request, data and acknowledge wires to the matching input of the neighbour. Unused edge inputs are tied low.

Top module: `mesh_xy_router`

## Requirements
- R1: While reset is held and after it is released with no traffic, every `out_req` bit and every `in_ack` bit is low.
- R2: The top two bits of a flit give its kind: 2'b01 opens a packet, 2'b00 is a middle flit, 2'b10 closes a packet, and 2'b11 is a packet of one flit. In an opening or one-flit packet, bits [COORD_W-1:0] hold the destination X and bits [2*COORD_W-1:COORD_W] hold the destination Y.
- R3: A packet is sent east (port 2) when its destination X is above MY_X and west (port 4) when it is below. Only when X matches does it go north (port 1) for a larger Y or south (port 3) for a smaller Y. North is the direction of increasing Y.
- R4: A packet whose destination equals (MY_X, MY_Y) leaves through the local port (port 0) and uses no neighbour link.
- R5: On each input, `in_ack` rises only after a flit has been taken while `in_req` is high, and falls once `in_req` has dropped.
- R6: On each output, `out_data` stays stable while `out_req` is high, `out_req` stays high until `out_ack` rises, and a new request is raised only after `out_ack` has returned low.
- R7: Once an output has been given to an input, it carries only that input's packet. Flits of different packets never interleave on one output.
- R8: An output is released only after the acknowledge of the packet's closing flit has completed. Any waiting packet may then win it.
- R9: When several inputs have opening flits waiting for the same output, they are served in round-robin order. With two inputs kept busy, they alternate packet by packet.
- R10: When a downstream node withholds its acknowledge, flits queue in the input buffers (DEPTH per input) and further upstream. None is lost, duplicated or reordered.
- R11: In a grid of nodes, every packet reaches its destination's local port complete and in its original flit order, whatever the source and destination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 5 | Per-input flit request (0 local, 1 north, 2 east, 3 south, 4 west) |
| in_data | input | 5 x FLIT_W | Per-input flit data, valid while the request is high |
| in_ack | output | 5 | Per-input acknowledge |
| out_req | output | 5 | Per-output flit request |
| out_data | output | 5 x FLIT_W | Per-output flit data, held while the request is high |
| out_ack | input | 5 | Per-output acknowledge from the receiver |

## Verification
Arbitration between two opening flits and the release of an output after a closing flit can happen in the same cycle. The release clears the old owner at the moment the competing packet becomes eligible. The bench provokes this by holding back the local acknowledge of the centre node of a 3x3 grid while its west and east neighbours each queue two packets for it. It then lets the acknowledge through, so that every release meets a waiting rival. The bench judges the outcome by the order of source identities at the sink, which must alternate, and by the sink's per-flit check that no packet is entered before the previous one has closed.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
   localparam int NPORT  = 5;
   localparam int PIDX_W = 3;

   typedef enum logic [PIDX_W-1:0] {
      P_LOCAL = 3'd0,
      P_NORTH = 3'd1,
      P_EAST  = 3'd2,
      P_SOUTH = 3'd3,
      P_WEST  = 3'd4
   } port_e;

   // flit kind in the top two bits: bit0 opens a packet, bit1 closes one
   typedef enum logic [1:0] {
      FK_MID    = 2'b00,
      FK_OPEN   = 2'b01,
      FK_CLOSE  = 2'b10,
      FK_SINGLE = 2'b11
   } fkind_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;
endpackage

// File: rtl/rtr_in_port.sv
module rtr_in_port import rtr_pkg::*; #(
   parameter int FLIT_W  = 32,
   parameter int COORD_W = 2,
   parameter int DEPTH   = 4,
   parameter int MY_X    = 0,
   parameter int MY_Y    = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 link_req,
   input  logic [FLIT_W-1:0]    link_data,
   output logic                 link_ack,
   output logic                 front_vld,
   output logic [FLIT_W-1:0]    front_data,
   output logic [PIDX_W-1:0]    front_route,
   input  logic                 pop
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CNT_W = $clog2(DEPTH + 1);
   localparam bit  POW2  = (DEPTH & (DEPTH - 1)) == 0;
   localparam logic [COORD_W-1:0] MYX = COORD_W'(MY_X);
   localparam logic [COORD_W-1:0] MYY = COORD_W'(MY_Y);

   logic [FLIT_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic [CNT_W-1:0]  cnt;
   logic              ack_q, full, push;
   logic [COORD_W-1:0] dx, dy;

   assign full       = cnt == CNT_W'(DEPTH);
   assign push       = link_req && !ack_q && !full;
   assign link_ack   = ack_q;
   assign front_vld  = cnt != '0;
   assign front_data = mem[rp];

   // four-phase receiver: take on req, drop ack after req falls
   always_ff @(posedge clk) begin
      if (!rst_n)                  ack_q <= 1'b0;
      else if (push)               ack_q <= 1'b1;
      else if (ack_q && !link_req) ack_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= link_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= (POW2 || wp != PTR_W'(DEPTH - 1)) ? wp + 1'b1 : '0;
         if (pop)  rp <= (POW2 || rp != PTR_W'(DEPTH - 1)) ? rp + 1'b1 : '0;
         cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      end
   end

   // dimension-ordered decision on the flit at the head of the buffer
   assign dx = front_data[COORD_W-1:0];
   assign dy = front_data[2*COORD_W-1:COORD_W];

   always_comb begin
      if (dx > MYX)      front_route = P_EAST;
      else if (dx < MYX) front_route = P_WEST;
      else if (dy > MYY) front_route = P_NORTH;
      else if (dy < MYY) front_route = P_SOUTH;
      else               front_route = P_LOCAL;
   end

   AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> front_vld);                                          // R10
   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_ack) |-> $past(link_req));                        // R5
   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (link_ack && !link_req) |=> !link_ack);                      // R5
endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
   parameter int N = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [N-1:0]                   req,
   input  logic                           en,
   output logic                           vld,
   output logic [(N > 1 ? $clog2(N) : 1)-1:0] idx
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic [IDX_W-1:0] last;

   generate
      if (N == 1) begin : g_single
         assign vld = req[0];
         assign idx = '0;
      end else begin : g_rr
         // search starts one place after the last winner
         always_comb begin
            vld = 1'b0;
            idx = '0;
            for (int k = 1; k <= N; k++) begin
               int c;
               c = (int'(last) + k) % N;
               if (!vld && req[c]) begin
                  vld = 1'b1;
                  idx = IDX_W'(c);
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)         last <= '0;
      else if (en && vld) last <= idx;
   end
endmodule

// File: rtl/rtr_out_port.sv
module rtr_out_port import rtr_pkg::*; #(
   parameter int FLIT_W = 32,
   parameter int N      = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N-1:0]           head_req,
   input  logic [N-1:0]           front_vld,
   input  logic [N-1:0][FLIT_W-1:0] front_data,
   output logic [N-1:0]           pop,
   output logic                   link_req,
   output logic [FLIT_W-1:0]      link_data,
   input  logic                   link_ack
);
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

   logic             locked, closing, take, send, arb_vld;
   logic [IDX_W-1:0] owner, arb_idx;
   logic [FLIT_W-1:0] cur;
   phase_e           ph;

   rtr_rr_arb #(.N(N)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (head_req),
      .en   (!locked),
      .vld  (arb_vld),
      .idx  (arb_idx)
   );

   assign take = !locked && arb_vld;
   assign cur  = front_data[owner];
   assign send = locked && !closing && ph == PH_IDLE && front_vld[owner];

   always_comb begin
      pop = '0;
      if (send) pop[owner] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked    <= 1'b0;
         closing   <= 1'b0;
         owner     <= '0;
         ph        <= PH_IDLE;
         link_req  <= 1'b0;
         link_data <= '0;
      end else begin
         if (take) begin
            locked <= 1'b1;
            owner  <= arb_idx;
         end
         case (ph)
            PH_IDLE: if (send) begin
               link_data <= cur;
               link_req  <= 1'b1;
               closing   <= cur[FLIT_W-1];
               ph        <= PH_REQ;
            end
            PH_REQ: if (link_ack) begin
               link_req <= 1'b0;
               ph       <= PH_WAIT;
            end
            PH_WAIT: if (!link_ack) begin
               ph <= PH_IDLE;
               if (closing) begin
                  locked  <= 1'b0;
                  closing <= 1'b0;
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

   AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && $past(link_req)) |-> $stable(link_data));      // R6
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (link_req && !link_ack) |=> link_req);                       // R6
   AST_REQ_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_req) |-> !$past(link_ack));                       // R6
   AST_OWNER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !closing) |=> (locked && $stable(owner)));        // R7
   AST_RELEASE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> (!link_req && !link_ack));                 // R8
endmodule

// File: rtl/mesh_xy_router.sv
module mesh_xy_router import rtr_pkg::*; #(
   parameter int FLIT_W  = 32,
   parameter int COORD_W = 2,
   parameter int DEPTH   = 4,
   parameter int MY_X    = 0,
   parameter int MY_Y    = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORT-1:0]              in_req,
   input  logic [NPORT-1:0][FLIT_W-1:0]  in_data,
   output logic [NPORT-1:0]              in_ack,
   output logic [NPORT-1:0]              out_req,
   output logic [NPORT-1:0][FLIT_W-1:0]  out_data,
   input  logic [NPORT-1:0]              out_ack
);
   generate
      if (FLIT_W < 2 * COORD_W + 2) begin : g_bad_width
         $error("flit too narrow for coordinates and kind field");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("buffer depth must be at least one");
      end
      if (MY_X >= (1 << COORD_W) || MY_Y >= (1 << COORD_W)) begin : g_bad_pos
         $error("node position does not fit the coordinate width");
      end
   endgenerate

   logic [NPORT-1:0]                f_vld;
   logic [NPORT-1:0][FLIT_W-1:0]    f_data;
   logic [NPORT-1:0][PIDX_W-1:0]    f_route;
   logic [NPORT-1:0][NPORT-1:0]     head_req;  // [output][input]
   logic [NPORT-1:0][NPORT-1:0]     pop_mx;    // [output][input]
   logic [NPORT-1:0][NPORT-1:0]     pop_col;   // [input][output]
   logic [NPORT-1:0]                pop_in;

   for (genvar i = 0; i < NPORT; i++) begin : g_in
      rtr_in_port #(
         .FLIT_W (FLIT_W),
         .COORD_W(COORD_W),
         .DEPTH  (DEPTH),
         .MY_X   (MY_X),
         .MY_Y   (MY_Y)
      ) u_in (
         .clk        (clk),
         .rst_n      (rst_n),
         .link_req   (in_req[i]),
         .link_data  (in_data[i]),
         .link_ack   (in_ack[i]),
         .front_vld  (f_vld[i]),
         .front_data (f_data[i]),
         .front_route(f_route[i]),
         .pop        (pop_in[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NPORT; o++) begin
         for (int i = 0; i < NPORT; i++) begin
            head_req[o][i] = f_vld[i] && f_data[i][FLIT_W-2]
                             && f_route[i] == PIDX_W'(o);
            pop_col[i][o]  = pop_mx[o][i];
         end
      end
      for (int i = 0; i < NPORT; i++) pop_in[i] = |pop_col[i];
   end

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      rtr_out_port #(
         .FLIT_W(FLIT_W),
         .N     (NPORT)
      ) u_out (
         .clk       (clk),
         .rst_n     (rst_n),
         .head_req  (head_req[o]),
         .front_vld (f_vld),
         .front_data(f_data),
         .pop       (pop_mx[o]),
         .link_req  (out_req[o]),
         .link_data (out_data[o]),
         .link_ack  (out_ack[o])
      );
   end

   for (genvar i = 0; i < NPORT; i++) begin : g_chk
      AST_SINGLE_DRAINER: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(pop_col[i]));                                    // R7
   end
endmodule

// File: tb/mesh_xy_router_bench.sv
module mesh_xy_router_bench;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 32;
   localparam int CW = 2;
   localparam int NN = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic          src_req  [NN];
   logic [FW-1:0] src_data [NN];
   logic          snk_ack  [NN];
   logic          stall    [NN];

   wire [4:0]         r_in_req   [NN];
   wire [4:0][FW-1:0] r_in_data  [NN];
   wire [4:0]         r_in_ack   [NN];
   wire [4:0]         r_out_req  [NN];
   wire [4:0][FW-1:0] r_out_data [NN];
   wire [4:0]         r_out_ack  [NN];

   int checks = 0;
   int errors = 0;
   int delivered [NN][NN];
   int lcnt [NN][5];
   int ord_src [16];
   int ord_n = 0;
   int src_done = 0;

   for (genvar n = 0; n < NN; n++) begin : g_node
      localparam int X = n % 3;
      localparam int Y = n / 3;
      mesh_xy_router #(.FLIT_W(FW), .COORD_W(CW), .DEPTH(4), .MY_X(X), .MY_Y(Y))
         u_mesh_xy_router (
            .clk(clk), .rst_n(rst_n),
            .in_req(r_in_req[n]), .in_data(r_in_data[n]), .in_ack(r_in_ack[n]),
            .out_req(r_out_req[n]), .out_data(r_out_data[n]), .out_ack(r_out_ack[n]));
      assign r_in_req[n][0]  = src_req[n];
      assign r_in_data[n][0] = src_data[n];
      assign r_out_ack[n][0] = snk_ack[n];
      if (Y < 2) begin : g_nb_n
         assign r_in_req[n][1]  = r_out_req[n+3][3];
         assign r_in_data[n][1] = r_out_data[n+3][3];
         assign r_out_ack[n][1] = r_in_ack[n+3][3];
      end else begin : g_edge_n
         assign r_in_req[n][1]  = 1'b0;
         assign r_in_data[n][1] = '0;
         assign r_out_ack[n][1] = 1'b0;
      end
      if (X < 2) begin : g_nb_e
         assign r_in_req[n][2]  = r_out_req[n+1][4];
         assign r_in_data[n][2] = r_out_data[n+1][4];
         assign r_out_ack[n][2] = r_in_ack[n+1][4];
      end else begin : g_edge_e
         assign r_in_req[n][2]  = 1'b0;
         assign r_in_data[n][2] = '0;
         assign r_out_ack[n][2] = 1'b0;
      end
      if (Y > 0) begin : g_nb_s
         assign r_in_req[n][3]  = r_out_req[n-3][1];
         assign r_in_data[n][3] = r_out_data[n-3][1];
         assign r_out_ack[n][3] = r_in_ack[n-3][1];
      end else begin : g_edge_s
         assign r_in_req[n][3]  = 1'b0;
         assign r_in_data[n][3] = '0;
         assign r_out_ack[n][3] = 1'b0;
      end
      if (X > 0) begin : g_nb_w
         assign r_in_req[n][4]  = r_out_req[n-1][2];
         assign r_in_data[n][4] = r_out_data[n-1][2];
         assign r_out_ack[n][4] = r_in_ack[n-1][2];
      end else begin : g_edge_w
         assign r_in_req[n][4]  = 1'b0;
         assign r_in_data[n][4] = '0;
         assign r_out_ack[n][4] = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // R2 flit layout: kind [31:30]; opener: dx [1:0], dy [3:2], src [7:4], pid [15:8]
   // later flits: src [7:4], pid [15:8], index [23:16]
   function automatic logic [FW-1:0] mk_flit(input int s, input int d, input int pid,
                                             input int idx, input int len);
      logic [1:0] kind;
      logic [FW-1:0] f;
      if (len == 1)            kind = 2'b11;
      else if (idx == 0)       kind = 2'b01;
      else if (idx == len - 1) kind = 2'b10;
      else                     kind = 2'b00;
      f = '0;
      f[31:30] = kind;
      f[7:4]   = 4'(s);
      f[15:8]  = 8'(pid);
      if (idx == 0) begin
         f[1:0] = 2'(d % 3);
         f[3:2] = 2'(d / 3);
      end else begin
         f[23:16] = 8'(idx);
      end
      return f;
   endfunction

   task automatic send_packet(input int s, input int d, input int pid, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         src_data[s] = mk_flit(s, d, pid, i, len);
         src_req[s]  = 1'b1;
         do @(negedge clk); while (!r_in_ack[s][0]);
         src_req[s] = 1'b0;
         do @(negedge clk); while (r_in_ack[s][0]);
      end
   endtask

   task automatic sink_proc(input int k);
      logic [FW-1:0] d;
      bit inpkt = 1'b0;
      int cs = 0, cp = 0, ci = 0;
      forever begin
         @(negedge clk);
         if (snk_req_of(k) && !snk_ack[k] && !stall[k]) begin
            d = r_out_data[k][0];
            if (d[30]) begin
               chk(!inpkt, "R7 opener inside open packet", int'(inpkt), 0);
               chk(int'(d[1:0]) == k % 3 && int'(d[3:2]) == k / 3, "R3 destination column/row",
                   int'(d[3:0]), (k / 3) * 4 + k % 3);
               cs = int'(d[7:4]); cp = int'(d[15:8]); ci = 1;
               inpkt = !d[31];
               if (d[31]) record(k, cs);
            end else begin
               chk(inpkt && int'(d[7:4]) == cs && int'(d[15:8]) == cp,
                   "R11 flit belongs to open packet", int'(d[15:4]), cp * 16 + cs);
               chk(int'(d[23:16]) == ci, "R11 flit order", int'(d[23:16]), ci);
               ci++;
               if (d[31]) begin
                  inpkt = 1'b0;
                  record(k, cs);
               end
            end
            snk_ack[k] = 1'b1;
            @(negedge clk);
            while (snk_req_of(k)) begin
               chk(r_out_data[k][0] == d, "R6 data stable under request",
                   int'(r_out_data[k][0]), int'(d));
               @(negedge clk);
            end
            snk_ack[k] = 1'b0;
         end
      end
   endtask

   function automatic bit snk_req_of(input int k);
      return r_out_req[k][0];
   endfunction

   task automatic record(input int k, input int s);
      delivered[s][k]++;
      if (k == 4 && ord_n < 16) begin
         ord_src[ord_n] = s;
         ord_n++;
      end
   endtask

   task automatic link_mon();
      logic [4:0] prev [NN];
      for (int n = 0; n < NN; n++) prev[n] = '0;
      forever begin
         @(negedge clk);
         for (int n = 0; n < NN; n++) begin
            for (int p = 0; p < 5; p++)
               if (r_out_req[n][p] && !prev[n][p]) lcnt[n][p]++;
            prev[n] = r_out_req[n];
         end
      end
   endtask

   task automatic clear_counts();
      for (int a = 0; a < NN; a++) begin
         for (int b = 0; b < NN; b++) delivered[a][b] = 0;
         for (int p = 0; p < 5; p++) lcnt[a][p] = 0;
      end
      ord_n = 0;
   endtask

   task automatic test_reset();
      for (int n = 0; n < NN; n++) begin
         chk(r_out_req[n] == 5'b0, "R1 out_req low in reset", int'(r_out_req[n]), 0);
         chk(r_in_ack[n] == 5'b0, "R1 in_ack low in reset", int'(r_in_ack[n]), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      for (int n = 0; n < NN; n++)
         chk(r_out_req[n] == 5'b0 && r_in_ack[n] == 5'b0, "R1 idle after reset",
             int'({r_out_req[n], r_in_ack[n]}), 0);
   endtask

   task automatic test_local();
      clear_counts();
      send_packet(4, 4, 7, 1);
      repeat (20) @(negedge clk);
      chk(delivered[4][4] == 1, "R4 self-addressed packet delivered", delivered[4][4], 1);
      chk(lcnt[4][1] + lcnt[4][2] + lcnt[4][3] + lcnt[4][4] == 0, "R4 no neighbour link used",
          lcnt[4][1] + lcnt[4][2] + lcnt[4][3] + lcnt[4][4], 0);
      chk(r_in_ack[4][0] == 1'b0, "R5 ack returned low", int'(r_in_ack[4][0]), 0);
   endtask

   task automatic test_xy_path();
      clear_counts();
      send_packet(0, 8, 1, 3);
      repeat (60) @(negedge clk);
      chk(lcnt[0][2] == 3 && lcnt[1][2] == 3, "R3 X leg east first", lcnt[0][2] + lcnt[1][2], 6);
      chk(lcnt[0][1] == 0 && lcnt[1][1] == 0, "R3 no early north", lcnt[0][1] + lcnt[1][1], 0);
      chk(lcnt[2][1] == 3 && lcnt[5][1] == 3, "R3 Y leg north", lcnt[2][1] + lcnt[5][1], 6);
      chk(delivered[0][8] == 1, "R11 corner to corner", delivered[0][8], 1);
      clear_counts();
      send_packet(8, 0, 2, 4);
      repeat (60) @(negedge clk);
      chk(lcnt[8][4] == 4 && lcnt[7][4] == 4, "R3 X leg west first", lcnt[8][4] + lcnt[7][4], 8);
      chk(lcnt[6][3] == 4 && lcnt[3][3] == 4, "R3 Y leg south", lcnt[6][3] + lcnt[3][3], 8);
      chk(delivered[8][0] == 1, "R11 reverse corner", delivered[8][0], 1);
   endtask

   task automatic test_contend_rr();
      clear_counts();
      src_done = 0;
      stall[4] = 1'b1;
      fork
         begin send_packet(3, 4, 31, 3); send_packet(3, 4, 32, 3); src_done++; end
         begin send_packet(5, 4, 51, 3); send_packet(5, 4, 52, 3); src_done++; end
      join_none
      repeat (300) @(negedge clk);
      chk(ord_n == 0, "R10 nothing delivered while held", ord_n, 0);
      chk(r_out_req[4][0] == 1'b1, "R10 flit offered and held", int'(r_out_req[4][0]), 1);
      stall[4] = 1'b0;
      while (src_done < 2) @(negedge clk);
      repeat (100) @(negedge clk);
      chk(ord_n == 4, "R10 all queued packets delivered", ord_n, 4);
      chk(delivered[3][4] == 2 && delivered[5][4] == 2, "R10 no loss per source",
          delivered[3][4] * 10 + delivered[5][4], 22);
      for (int i = 1; i < 4; i++)
         chk(ord_src[i] != ord_src[i-1], "R9 round-robin alternation after R8 release",
             ord_src[i], 8 - ord_src[i-1]);
   endtask

   task automatic test_all_pairs();
      clear_counts();
      for (int s = 0; s < NN; s++) begin
         fork
            automatic int ss = s;
            begin
               for (int d = 0; d < NN; d++)
                  if (d != ss) send_packet(ss, d, ss * 16 + d, 1 + (ss + d) % 4);
            end
         join_none
      end
      wait fork;
   endtask

   task automatic check_all_pairs();
      repeat (200) @(negedge clk);
      for (int s = 0; s < NN; s++)
         for (int d = 0; d < NN; d++)
            if (d != s)
               chk(delivered[s][d] == 1, "R2 R11 every pair delivered once",
                   delivered[s][d], 1);
   endtask

   initial begin
      for (int n = 0; n < NN; n++) begin
         src_req[n] = 1'b0; src_data[n] = '0; snk_ack[n] = 1'b0; stall[n] = 1'b0;
      end
      clear_counts();
      fork
         begin
            fork
               link_mon();
               for (int n = 0; n < NN; n++) begin
                  fork
                     automatic int kk = n;
                     sink_proc(kk);
                  join_none
               end
            join_none
            repeat (4) @(negedge clk);
            test_reset();
            test_local();
            test_xy_path();
            test_contend_rr();
            fork
               test_all_pairs();
            join
            check_all_pairs();
         end
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule